// File: doc/BRIEF.md
# Segment Translation Unit with Cached Descriptors

This block turns a segment-relative reference (a segment register number plus a 16-bit offset) into a 24-bit physical address. It holds one cached descriptor per segment register, four in all. Each descriptor records the segment register value, a 24-bit base, a 16-bit limit and a 4-bit rights field. The surrounding pipeline supplies the complete descriptor on the load port whenever it writes a segment register. After that, every reference through that segment is checked and translated with no memory lookup.

In real mode the address is the segment value times sixteen plus the offset, and no checks are applied. In protected mode each reference is checked first, and this includes instruction fetches. The unit checks the cached rights against the kind of access and the last byte touched against the cached limit. A reference that fails raises a fault with a cause code and gives no address. A reference that passes gives base plus offset. Results are registered and appear one clock after the request. The cached descriptors cannot be read back through any port. Only the translation path uses them.

Top module: `seg_xlate_unit`

## Requirements
- R1: In a cycle whose edge sees rst_n low, all outputs go to zero on that edge and every cached entry is cleared to zero. A protected reference made right after reset therefore faults with cause 1.
- R2: On an edge where ref_en_i is low, addr_vld_o, fault_o, fault_cause_o and addr_o are all zero after that edge.
- R3: When prot_i is low, a reference gives addr_vld_o=1 and addr_o = segment value * 16 + offset, zero-extended to 24 bits. This ignores rights, limit and access kind, and the result appears one clock after the request.
- R4: When ld_en_i is high, the entry chosen by ld_sel_i captures ld_seg_i, ld_base_i, ld_limit_i and ld_rights_i. The other three entries keep their contents.
- R5: A protected reference that passes all checks gives addr_vld_o=1 and addr_o = (base + offset) mod 2^24.
- R6: The rights field uses bit 0 for present, bit 1 for readable, bit 2 for writable and bit 3 for executable. A protected reference through a segment whose present bit is 0 faults with cause 1, whatever its kind or offset.
- R7: ref_kind_i is encoded 0=read, 1=write, 2=fetch and 3=read. On a present segment, a write without the writable bit faults with cause 3. A fetch without the executable bit faults with cause 4. A read without the readable bit faults with cause 5. These rights faults take precedence over a limit fault.
- R8: The last byte touched is offset + ref_size_i, where ref_size_i is the access size in bytes minus 1. If that value exceeds the cached limit, the reference faults with cause 2. The sum is taken without wrap, in 17 bits.
- R9: addr_vld_o and fault_o are never high together. fault_cause_o is nonzero exactly when fault_o is high, and addr_o is zero whenever addr_vld_o is low.
- R10: A load and a reference to the same entry in one cycle use the newly loaded value. This holds in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_i | input | 1 | 1 = protected mode, 0 = real mode |
| ld_en_i | input | 1 | Load a segment register and its descriptor |
| ld_sel_i | input | 2 | Entry to load |
| ld_seg_i | input | 16 | Segment register value |
| ld_base_i | input | 24 | Descriptor base |
| ld_limit_i | input | 16 | Descriptor limit (highest valid offset) |
| ld_rights_i | input | 4 | Rights: present, readable, writable, executable (bits 0..3) |
| ref_en_i | input | 1 | Reference request |
| ref_sel_i | input | 2 | Entry used by the reference |
| ref_off_i | input | 16 | Offset |
| ref_kind_i | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| ref_size_i | input | 2 | Access size in bytes minus 1 |
| addr_vld_o | output | 1 | Physical address valid |
| addr_o | output | 24 | Physical address |
| fault_o | output | 1 | Reference rejected |
| fault_cause_o | output | 3 | 0 none, 1 not present, 2 limit, 3 write, 4 fetch, 5 read |

## Verification
Every result is registered once, so the outcome of a reference driven before a rising edge is due right after that edge. The bench drives each request just after a falling edge and samples on the next falling edge, which is half a period after the capturing edge. A load alone takes effect at the same edge, so a later reference sees it. A load paired with a reference in the same cycle is checked in that same single-cycle window. Expected addresses and causes come from a model in the bench that keeps its own copy of every loaded descriptor. The bench sweeps all sixteen rights values, every kind and size, and offsets that straddle the limit.

// File: rtl/seg_xlate_pkg.sv
// Shared encodings for the segment translation unit.
// Assumes: rights field is 4 bits; cause codes fit in 3 bits.
package seg_xlate_pkg;
    localparam int RT_PRESENT = 0;
    localparam int RT_READ    = 1;
    localparam int RT_WRITE   = 2;
    localparam int RT_EXEC    = 3;
    localparam int RT_W       = 4;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_READ2 = 2'd3
    } ref_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_ABSENT  = 3'd1,
        CAUSE_LIMIT   = 3'd2,
        CAUSE_NOWRITE = 3'd3,
        CAUSE_NOEXEC  = 3'd4,
        CAUSE_NOREAD  = 3'd5
    } fault_cause_e;
endpackage

// File: rtl/seg_desc_store.sv
// Holds one cached descriptor per segment register and returns the entry
// picked by rd_sel_i. A load to the same entry in the same cycle is
// forwarded to the read side. Assumes: synchronous active-low reset clears all.
module seg_desc_store #(
    parameter int NSEG  = 4,
    parameter int SEG_W = 16,
    parameter int PA_W  = 24,
    parameter int LIM_W = 16,
    parameter int RT_W  = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en_i,
    input  logic [SEL_W-1:0] ld_sel_i,
    input  logic [SEG_W-1:0] ld_seg_i,
    input  logic [PA_W-1:0]  ld_base_i,
    input  logic [LIM_W-1:0] ld_limit_i,
    input  logic [RT_W-1:0]  ld_rights_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [SEG_W-1:0] rd_seg_o,
    output logic [PA_W-1:0]  rd_base_o,
    output logic [LIM_W-1:0] rd_limit_o,
    output logic [RT_W-1:0]  rd_rights_o
);
    logic [SEG_W-1:0] seg_q    [NSEG];
    logic [PA_W-1:0]  base_q   [NSEG];
    logic [LIM_W-1:0] limit_q  [NSEG];
    logic [RT_W-1:0]  rights_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        // Capture the descriptor when this entry is loaded.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g]    <= '0;
                base_q[g]   <= '0;
                limit_q[g]  <= '0;
                rights_q[g] <= '0;
            end else if (ld_en_i && (ld_sel_i == SEL_W'(g))) begin
                seg_q[g]    <= ld_seg_i;
                base_q[g]   <= ld_base_i;
                limit_q[g]  <= ld_limit_i;
                rights_q[g] <= ld_rights_i;
            end
        end
    end

    logic fwd;

    // Select the stored entry, or the incoming load when it targets it.
    always_comb begin
        fwd = ld_en_i && (ld_sel_i == rd_sel_i);
        if (fwd) begin
            rd_seg_o    = ld_seg_i;
            rd_base_o   = ld_base_i;
            rd_limit_o  = ld_limit_i;
            rd_rights_o = ld_rights_i;
        end else begin
            rd_seg_o    = seg_q[rd_sel_i];
            rd_base_o   = base_q[rd_sel_i];
            rd_limit_o  = limit_q[rd_sel_i];
            rd_rights_o = rights_q[rd_sel_i];
        end
    end
endmodule

// File: rtl/seg_ref_check.sv
// Combinational protection check for one reference: presence, rights for
// the access kind, then the limit. Assumes: offset and limit have equal width.
module seg_ref_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W  = 16,
    parameter int LIM_W  = 16,
    parameter int SIZE_W = 2
) (
    input  logic [RT_W-1:0]   rights_i,
    input  logic [LIM_W-1:0]  limit_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [1:0]        kind_i,
    output logic [2:0]        cause_o
);
    localparam int END_W = OFF_W + 1;

    logic [END_W-1:0] last_byte;
    logic             over_limit;

    // Locate the last byte touched and compare it with the limit.
    always_comb begin
        last_byte  = END_W'(off_i) + END_W'(size_i);
        over_limit = last_byte > END_W'(limit_i);
    end

    // Pick the highest-priority violation.
    always_comb begin
        cause_o = CAUSE_NONE;
        if (!rights_i[RT_PRESENT])
            cause_o = CAUSE_ABSENT;
        else if ((kind_i == KIND_WRITE) && !rights_i[RT_WRITE])
            cause_o = CAUSE_NOWRITE;
        else if ((kind_i == KIND_FETCH) && !rights_i[RT_EXEC])
            cause_o = CAUSE_NOEXEC;
        else if (((kind_i == KIND_READ) || (kind_i == KIND_READ2)) && !rights_i[RT_READ])
            cause_o = CAUSE_NOREAD;
        else if (over_limit)
            cause_o = CAUSE_LIMIT;
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Forms the physical address: shifted segment plus offset in real mode,
// descriptor base plus offset in protected mode, wrapping at PA_W bits.
module seg_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 24,
    parameter int SHIFT = 4
) (
    input  logic             prot_i,
    input  logic [SEG_W-1:0] seg_i,
    input  logic [PA_W-1:0]  base_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PA_W-1:0]  pa_o
);
    logic [PA_W-1:0] origin;

    // Choose the segment origin and add the offset.
    always_comb begin
        origin = prot_i ? base_i : PA_W'({seg_i, SHIFT'(0)});
        pa_o   = origin + PA_W'(off_i);
    end
endmodule

// File: rtl/seg_xlate_unit.sv
// Top of the segment translation unit: descriptor store, protection check
// and address adder, with one register stage on the result.
// Assumes: loads and references are single-cycle pulses; no backpressure.
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int NSEG   = 4,
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int LIM_W  = 16,
    parameter int PA_W   = 24,
    parameter int SIZE_W = 2,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_i,
    input  logic              ld_en_i,
    input  logic [SEL_W-1:0]  ld_sel_i,
    input  logic [SEG_W-1:0]  ld_seg_i,
    input  logic [PA_W-1:0]   ld_base_i,
    input  logic [LIM_W-1:0]  ld_limit_i,
    input  logic [RT_W-1:0]   ld_rights_i,
    input  logic              ref_en_i,
    input  logic [SEL_W-1:0]  ref_sel_i,
    input  logic [OFF_W-1:0]  ref_off_i,
    input  logic [1:0]        ref_kind_i,
    input  logic [SIZE_W-1:0] ref_size_i,
    output logic              addr_vld_o,
    output logic [PA_W-1:0]   addr_o,
    output logic              fault_o,
    output logic [2:0]        fault_cause_o
);
    logic [SEG_W-1:0] cur_seg;
    logic [PA_W-1:0]  cur_base;
    logic [LIM_W-1:0] cur_limit;
    logic [RT_W-1:0]  cur_rights;
    logic [2:0]       chk_cause;
    logic [PA_W-1:0]  pa;

    seg_desc_store #(
        .NSEG(NSEG), .SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W), .RT_W(RT_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_seg_i(ld_seg_i),
        .ld_base_i(ld_base_i), .ld_limit_i(ld_limit_i), .ld_rights_i(ld_rights_i),
        .rd_sel_i(ref_sel_i),
        .rd_seg_o(cur_seg), .rd_base_o(cur_base),
        .rd_limit_o(cur_limit), .rd_rights_o(cur_rights)
    );

    seg_ref_check #(
        .OFF_W(OFF_W), .LIM_W(LIM_W), .SIZE_W(SIZE_W)
    ) check_i (
        .rights_i(cur_rights), .limit_i(cur_limit), .off_i(ref_off_i),
        .size_i(ref_size_i), .kind_i(ref_kind_i), .cause_o(chk_cause)
    );

    seg_addr_gen #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .SHIFT(4)
    ) adder_i (
        .prot_i(prot_i), .seg_i(cur_seg), .base_i(cur_base),
        .off_i(ref_off_i), .pa_o(pa)
    );

    logic [2:0] eff_cause;

    // Real mode skips every protection check.
    always_comb eff_cause = prot_i ? chk_cause : CAUSE_NONE;

    // Register the outcome of the reference.
    always_ff @(posedge clk) begin
        if (!rst_n || !ref_en_i) begin
            addr_vld_o    <= 1'b0;
            addr_o        <= '0;
            fault_o       <= 1'b0;
            fault_cause_o <= CAUSE_NONE;
        end else if (eff_cause != CAUSE_NONE) begin
            addr_vld_o    <= 1'b0;
            addr_o        <= '0;
            fault_o       <= 1'b1;
            fault_cause_o <= eff_cause;
        end else begin
            addr_vld_o    <= 1'b1;
            addr_o        <= pa;
            fault_o       <= 1'b0;
            fault_cause_o <= CAUSE_NONE;
        end
    end
endmodule

// File: rtl/seg_xlate_unit_chk.sv
// Port-level checker for seg_xlate_unit, attached by bind.
module seg_xlate_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        prot_i,
    input logic        ld_en_i,
    input logic [1:0]  ld_sel_i,
    input logic [3:0]  ld_rights_i,
    input logic        ref_en_i,
    input logic [1:0]  ref_sel_i,
    input logic        addr_vld_o,
    input logic [23:0] addr_o,
    input logic        fault_o,
    input logic [2:0]  fault_cause_o
);
    // R9: valid and fault never together
    a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_vld_o && fault_o));
    // R9: cause nonzero exactly with fault
    a_r9_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o == (fault_cause_o != 3'd0));
    // R9: address zero unless valid
    a_r9_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld_o |-> addr_o == 24'd0);
    // R2: no request gives a quiet result
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en_i |=> !(addr_vld_o || fault_o));
    // R3: real-mode requests always translate
    a_r3_real_vld: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en_i && !prot_i |=> addr_vld_o);
    // R10: same-cycle load of an absent descriptor faults the reference
    a_r10_fwd_absent: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en_i && prot_i && ld_en_i && ld_sel_i == ref_sel_i && !ld_rights_i[0]
        |=> fault_o && fault_cause_o == 3'd1);
endmodule

bind seg_xlate_unit seg_xlate_unit_chk chk_i (
    .clk(clk), .rst_n(rst_n), .prot_i(prot_i),
    .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_rights_i(ld_rights_i),
    .ref_en_i(ref_en_i), .ref_sel_i(ref_sel_i),
    .addr_vld_o(addr_vld_o), .addr_o(addr_o),
    .fault_o(fault_o), .fault_cause_o(fault_cause_o)
);

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_i = 1'b0;
    logic        ld_en_i = 1'b0;
    logic [1:0]  ld_sel_i = '0;
    logic [15:0] ld_seg_i = '0;
    logic [23:0] ld_base_i = '0;
    logic [15:0] ld_limit_i = '0;
    logic [3:0]  ld_rights_i = '0;
    logic        ref_en_i = 1'b0;
    logic [1:0]  ref_sel_i = '0;
    logic [15:0] ref_off_i = '0;
    logic [1:0]  ref_kind_i = '0;
    logic [1:0]  ref_size_i = '0;
    logic        addr_vld_o;
    logic [23:0] addr_o;
    logic        fault_o;
    logic [2:0]  fault_cause_o;

    int checks = 0;
    int failures = 0;

    logic [15:0] m_seg [4];
    logic [23:0] m_base [4];
    logic [15:0] m_lim [4];
    logic [3:0]  m_rt [4];

    always #2 clk = ~clk;

    seg_xlate_unit dut_i (.*);

    task automatic check(string req, logic av, logic [23:0] aa, logic af, logic [2:0] ac,
                         logic ev, logic [23:0] ea, logic ef, logic [2:0] ec);
        checks++;
        if (av !== ev || aa !== ea || af !== ef || ac !== ec) begin
            failures++;
            $display("FAIL %s: got vld=%0b addr=%h fault=%0b cause=%0d exp vld=%0b addr=%h fault=%0b cause=%0d",
                     req, av, aa, af, ac, ev, ea, ef, ec);
        end
    endtask

    function automatic logic [2:0] exp_cause(logic p, int s, logic [15:0] off, logic [1:0] k, logic [1:0] sz);
        logic [3:0] rt;
        rt = m_rt[s];
        if (!p) return 3'd0;
        if (!rt[0]) return 3'd1;
        if (k == 2'd1 && !rt[2]) return 3'd3;
        if (k == 2'd2 && !rt[3]) return 3'd4;
        if ((k == 2'd0 || k == 2'd3) && !rt[1]) return 3'd5;
        if (int'(off) + int'(sz) > int'(m_lim[s])) return 3'd2;
        return 3'd0;
    endfunction

    function automatic logic [23:0] exp_addr(logic p, int s, logic [15:0] off);
        if (p) return 24'((int'(m_base[s]) + int'(off)) & 24'hFFFFFF);
        return 24'(int'(m_seg[s]) * 16 + int'(off));
    endfunction

    // Set up a load for the next edge; model updates at that edge.
    task automatic set_load(int s, logic [15:0] sg, logic [23:0] b, logic [15:0] l, logic [3:0] r);
        ld_en_i = 1'b1; ld_sel_i = 2'(s); ld_seg_i = sg;
        ld_base_i = b; ld_limit_i = l; ld_rights_i = r;
    endtask

    task automatic commit_load(int s);
        m_seg[s] = ld_seg_i; m_base[s] = ld_base_i;
        m_lim[s] = ld_limit_i; m_rt[s] = ld_rights_i;
    endtask

    task automatic do_load(int s, logic [15:0] sg, logic [23:0] b, logic [15:0] l, logic [3:0] r);
        set_load(s, sg, b, l, r);
        @(negedge clk);
        commit_load(s);
        ld_en_i = 1'b0;
    endtask

    // Reference issued after a falling edge, result sampled at the next one.
    // If a load is pending on the same entry it is committed to the model first.
    task automatic do_ref(string req, logic p, int s, logic [15:0] off, logic [1:0] k, logic [1:0] sz);
        logic [2:0] c;
        logic [23:0] a;
        prot_i = p; ref_en_i = 1'b1; ref_sel_i = 2'(s);
        ref_off_i = off; ref_kind_i = k; ref_size_i = sz;
        if (ld_en_i) commit_load(int'(ld_sel_i));
        c = exp_cause(p, s, off, k, sz);
        a = exp_addr(p, s, off);
        @(negedge clk);
        ld_en_i = 1'b0;
        ref_en_i = 1'b0;
        if (c != 3'd0) check(req, addr_vld_o, addr_o, fault_o, fault_cause_o, 1'b0, 24'd0, 1'b1, c);
        else           check(req, addr_vld_o, addr_o, fault_o, fault_cause_o, 1'b1, a, 1'b0, 3'd0);
    endtask

    initial begin
        #(4.0 * 150000);
        failures++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_seg[i] = '0; m_base[i] = '0; m_lim[i] = '0; m_rt[i] = '0;
        end
        // R1: reset with a pending request still yields zero outputs
        ref_en_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", addr_vld_o, addr_o, fault_o, fault_cause_o, 1'b0, 24'd0, 1'b0, 3'd0);
        ref_en_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle cycle
        check("R2 idle", addr_vld_o, addr_o, fault_o, fault_cause_o, 1'b0, 24'd0, 1'b0, 3'd0);
        // R1: cleared entries are absent in protected mode
        for (int s = 0; s < 4; s++) do_ref("R1 cleared entry", 1'b1, s, 16'h0, 2'd0, 2'd0);

        // R3: real-mode sweep with rights absent, kinds and sizes ignored
        for (int i = 0; i < 64; i++) begin
            int s = i % 4;
            do_load(s, 16'(i * 16'h0421 + (i % 2) * 16'hF000), 24'h0, 16'h0, 4'h0);
            do_ref("R3 real mode", 1'b0, s, 16'(i * 16'h0403 + (i / 32) * 16'hFF00), 2'(i), 2'(i / 4));
        end
        do_load(3, 16'hFFFF, 24'h0, 16'h0, 4'h0);
        do_ref("R3 real mode top", 1'b0, 3, 16'hFFFF, 2'd1, 2'd3);

        // R4: load all entries, then read each back through translation
        for (int s = 0; s < 4; s++)
            do_load(s, 16'(s * 16'h1111), 24'(s * 24'h3F0001 + 24'h000100), 16'(16'h0FFF + s * 16'h1000), 4'hF);
        for (int s = 0; s < 4; s++) do_ref("R4 entry kept", 1'b1, s, 16'h0123, 2'd0, 2'd1);

        // R5: base wrap at 24 bits
        do_load(2, 16'h0, 24'hFFFF00, 16'hFFFF, 4'hF);
        do_ref("R5 base wrap", 1'b1, 2, 16'h0200, 2'd2, 2'd0);
        do_ref("R5 base add", 1'b1, 2, 16'h00FF, 2'd1, 2'd0);

        // R6 R7 R8: sweep every rights value, kind, size and offsets around the limit
        for (int r = 0; r < 16; r++) begin
            do_load(1, 16'h0, 24'h123400 + 24'(r), 16'h8000, 4'(r));
            for (int k = 0; k < 4; k++)
                for (int z = 0; z < 4; z++)
                    for (int o = 0; o < 7; o++) begin
                        logic [15:0] off;
                        case (o)
                            0: off = 16'h0000;
                            1: off = 16'h7FFC;
                            2: off = 16'h7FFD;
                            3: off = 16'h7FFE;
                            4: off = 16'h7FFF;
                            5: off = 16'h8000;
                            default: off = 16'hFFFF;
                        endcase
                        do_ref(r[0] ? "R7 R8 rights and limit" : "R6 absent", 1'b1, 1, off, 2'(k), 2'(z));
                    end
        end
        // R8: limit at the top with no wrap of offset+size
        do_load(0, 16'h0, 24'h0, 16'hFFFF, 4'hF);
        do_ref("R8 top limit ok", 1'b1, 0, 16'hFFFF, 2'd0, 2'd0);
        do_ref("R8 top limit over", 1'b1, 0, 16'hFFFF, 2'd0, 2'd1);

        // R10: same-cycle load and reference
        set_load(3, 16'h0ABC, 24'h400000, 16'h0010, 4'h1);
        do_ref("R10 bypass protected", 1'b1, 3, 16'h0008, 2'd1, 2'd0);
        set_load(3, 16'h0ABC, 24'h400000, 16'h0010, 4'h0);
        do_ref("R10 bypass absent", 1'b1, 3, 16'h0008, 2'd0, 2'd0);
        set_load(0, 16'h2222, 24'h0, 16'h0, 4'h0);
        do_ref("R10 bypass real", 1'b0, 0, 16'h0005, 2'd0, 2'd0);
        // R4: other entry loaded while referencing a different one
        set_load(2, 16'h7777, 24'h777777, 16'h0, 4'h0);
        do_ref("R4 other entry", 1'b1, 1, 16'h0000, 2'd0, 2'd0);
        do_ref("R4 loaded entry", 1'b1, 2, 16'h0000, 2'd0, 2'd0);

        @(negedge clk);
        check("R2 idle end", addr_vld_o, addr_o, fault_o, fault_cause_o, 1'b0, 24'd0, 1'b0, 3'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule